// File: doc/BRIEF.md
# Rolling Activation Window Limiter

This block gates row-open (ACTIVATE) commands for one DRAM device or rank. It looks at every bank of that device together. It applies two limits that bound peak supply current. The first is a minimum spacing between any two activations, whatever their banks. The second is a cap on how many activations may fall inside any sliding window of cycles. Outside these two limits, activations to different banks are unconstrained, so the block has no bank input.

The command scheduler raises `act_req` when it has a row open ready to go. It reads `act_allow` or `act_grant` in the same cycle. It pulses `act_issued` in each cycle in which it actually puts an ACTIVATE on the command bus. The request and grant pair works like a ready handshake without buffering. The scheduler may hold a request for as long as it likes, and a request on its own changes no state. Only `act_issued` moves the timers. An issue that is made while the block forbids it is still recorded, and it also sets a sticky error flag.

Internally, one countdown timer enforces the spacing. A ring of countdown timers, one per window slot, holds the ages of the most recent activations. A new activation is allowed only when the slot holding the oldest of them has run out.

Top module: `act_window_limiter`

## Requirements
- R1: After reset, `act_allow` is 1 and `proto_err` is 0, and both stay that way until the first issue.
- R2: After an issue sampled at clock edge t, `act_allow` is 0 for any issue at edges t+1 to t+RRD_CYC-1. The spacing constraint is met again from edge t+RRD_CYC.
- R3: If the WINDOW_ACTS-th most recent issue was at edge t, no further issue is allowed before edge t+FAW_CYC. As a result, any FAW_CYC consecutive edges contain at most WINDOW_ACTS permitted issues.
- R4: Straight after reset, the first WINDOW_ACTS issues are limited only by the spacing of R2.
- R5: `act_allow` is 1 in exactly those cycles in which both R2 and R3 permit an issue at the coming edge. There is no extra cycle of delay.
- R6: `act_grant` equals `act_req` AND `act_allow` in the same cycle. A request without `act_issued` changes no timer.
- R7: An edge with `act_issued`=1 while `act_allow`=0 sets `proto_err` from the next cycle on. Only reset clears it.
- R8: An issue that is not permitted still counts toward both the spacing and the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req | input | 1 | Scheduler has an activation ready |
| act_issued | input | 1 | An activation goes onto the command bus this cycle |
| act_allow | output | 1 | An activation at the coming edge meets both limits |
| act_grant | output | 1 | Request present and permitted |
| proto_err | output | 1 | Sticky: an activation was issued while not permitted |

## Verification
The bench builds the block with a spacing of 3 cycles, a window of 16 cycles and 4 slots. Because four spaced issues fill only 9 cycles of the 16-cycle window, the window limit, and not the spacing, decides every fifth issue. Dense traffic therefore shows both limits taking turns.

A small window also brings forced illegal bursts within reach of a few cycles. Those bursts show that issues made without permission still fill the ring and restart the spacing.

// File: rtl/act_lim_pkg.sv
package act_lim_pkg;

  // width of a countdown that must hold values 0..max_val
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

  // width of a ring pointer over n entries
  function automatic int ptr_width(input int n);
    return (n > 1) ? cnt_width(n - 1) : 1;
  endfunction

endpackage

// File: rtl/act_gap_timer.sv
module act_gap_timer
  import act_lim_pkg::*;
#(
  parameter int SPAN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int MAXV = (SPAN > 1) ? SPAN - 1 : 1;
  localparam int W    = cnt_width(MAXV);
  localparam logic [W-1:0] LOADV = W'(SPAN - 1);

  logic [W-1:0] cnt;

  // counts down to zero; zero means another event may happen at this edge
  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= LOADV;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  generate
    if (SPAN > 1) begin : g_blk_chk
      // R2
      load_blocks_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);
    end
  endgenerate

endmodule

// File: rtl/act_window_tracker.sv
module act_window_tracker
  import act_lim_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SPAN  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  output logic room
);
  localparam int PW = ptr_width(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0]    oldest;
  logic [DEPTH-1:0] slot_load;
  logic [DEPTH-1:0] slot_free;

  // the slot under the pointer holds the oldest of the last DEPTH issues
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign slot_load[i] = issue && (oldest == PW'(i));
      act_gap_timer #(.SPAN(SPAN)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (slot_load[i]),
        .expired (slot_free[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     oldest <= '0;
    else if (issue) oldest <= (oldest == LAST) ? '0 : oldest + 1'b1;
  end

  assign room = slot_free[oldest];

  // R3
  slot_load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_load));

  generate
    if (SPAN > 1 && DEPTH == 1) begin : g_single
      // R3
      single_slot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !room);
    end
  endgenerate

endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int RRD_CYC     = 4,
  parameter int FAW_CYC     = 20,
  parameter int WINDOW_ACTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_req,
  input  logic act_issued,
  output logic act_allow,
  output logic act_grant,
  output logic proto_err
);
  logic gap_ok;
  logic win_room;
  logic err_q;

  act_gap_timer #(.SPAN(RRD_CYC)) u_spacing (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (act_issued),
    .expired (gap_ok)
  );

  act_window_tracker #(.DEPTH(WINDOW_ACTS), .SPAN(FAW_CYC)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (act_issued),
    .room  (win_room)
  );

  assign act_allow = gap_ok && win_room;
  assign act_grant = act_req && act_allow;

  always_ff @(posedge clk) begin
    if (!rst_n)                       err_q <= 1'b0;
    else if (act_issued && !act_allow) err_q <= 1'b1;
  end

  assign proto_err = err_q;

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_issued && !act_allow) |=> proto_err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R6
  grant_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_grant |-> (act_allow && act_req));

  generate
    if (RRD_CYC > 1) begin : g_rrd_chk
      // R8
      any_issue_spaces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_issued |=> !act_allow);
    end
  endgenerate

endmodule

// File: tb/tb_act_window_limiter.sv
module tb_act_window_limiter;
  localparam int RRD  = 3;
  localparam int FAW  = 16;
  localparam int NACT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_req = 1'b0;
  logic act_issued = 1'b0;
  logic act_allow, act_grant, proto_err;

  act_window_limiter #(.RRD_CYC(RRD), .FAW_CYC(FAW), .WINDOW_ACTS(NACT)) dut (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_issued(act_issued),
    .act_allow(act_allow), .act_grant(act_grant), .proto_err(proto_err)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  int hist[$];
  int exp_q[$];
  bit err_m;
  bit sb_on = 1'b0;
  int sb_seen = 0;
  int popped;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit model_allow(input int nxt);
    int n;
    n = hist.size();
    model_allow = 1'b1;
    if (n > 0 && nxt - hist[n-1] < RRD) model_allow = 1'b0;
    if (n >= NACT && nxt - hist[n-NACT] < FAW) model_allow = 1'b0;
  endfunction

  // scoreboard monitor: compares each issue edge with the expected schedule
  always @(posedge clk) begin
    if (rst_n && act_issued && sb_on) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected issue", cyc + 1, -1);
      else begin
        popped = exp_q.pop_front();
        chk(cyc + 1 == popped, (sb_seen < NACT) ? "R4 issue edge" : "R3 issue edge",
            cyc + 1, popped);
      end
      sb_seen++;
    end
  end

  // called at a falling edge; mode 0 idle, 1 issue when granted, 2 forced issue
  task automatic step(input bit req, input int mode, input string tag);
    bit exp;
    bit iss;
    act_req = req;
    act_issued = 1'b0;
    #1;
    chk(proto_err == err_m, "R7 err flag", proto_err, err_m);
    exp = model_allow(cyc + 1);
    chk(act_allow == exp, tag, act_allow, exp);
    chk(act_grant == (req && exp), "R6 grant", act_grant, req && exp);
    iss = (mode == 2) || (mode == 1 && act_grant);
    act_issued = iss;
    if (iss) begin
      if (!exp) err_m = 1'b1;
      hist.push_back(cyc + 1);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    act_req = 1'b0;
    act_issued = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hist.delete();
    err_m = 1'b0;
    #1;
    chk(act_allow == 1'b1, "R1 allow after reset", act_allow, 1);
    chk(proto_err == 1'b0, "R1 err after reset", proto_err, 0);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int e;
    int t[$];
    @(negedge clk);
    do_reset();
    // R1: idle cycles keep reset state
    repeat (4) step(1'b0, 0, "R1 idle allow");

    // dense traffic: R2 R3 R4 R5
    e = cyc + 1;
    for (int i = 0; i < 13; i++) begin
      int v;
      if (i == 0) v = e;
      else begin
        v = t[i-1] + RRD;
        if (i >= NACT && t[i-NACT] + FAW > v) v = t[i-NACT] + FAW;
      end
      t.push_back(v);
      exp_q.push_back(v);
    end
    sb_on = 1'b1;
    sb_seen = 0;
    while (hist.size() < 13) step(1'b1, 1, "R5 allow dense");
    sb_on = 1'b0;
    chk(exp_q.size() == 0, "R3 schedule consumed", exp_q.size(), 0);
    for (int i = 1; i < hist.size(); i++)
      chk(hist[i] - hist[i-1] >= RRD, "R2 gap", hist[i] - hist[i-1], RRD);
    for (int i = 0; i + NACT < hist.size(); i++)
      chk(hist[i+NACT] - hist[i] >= FAW, "R3 five-issue span", hist[i+NACT] - hist[i], FAW);

    // R6: requests without issue leave timers alone
    do_reset();
    step(1'b1, 2, "R2 first issue");
    repeat (10) step(1'b1, 0, "R6 request only");
    repeat (3) step(1'b0, 0, "R6 idle");
    step(1'b1, 1, "R6 granted issue");
    repeat (4) step(1'b0, 0, "R2 after issue");

    // R7 R8: illegal issues set the flag and still count
    do_reset();
    step(1'b1, 1, "R4 first");
    step(1'b1, 2, "R7 illegal spacing");
    repeat (5) step(1'b0, 0, "R8 spacing restarts");
    step(1'b0, 2, "R8 legal third");
    step(1'b0, 2, "R8 illegal fourth");
    repeat (20) step(1'b0, 0, "R8 window includes illegal");
    chk(proto_err == 1'b1, "R7 sticky", proto_err, 1);

    do_reset();
    chk(proto_err == 1'b0, "R7 cleared by reset", proto_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule